// File: doc/BRIEF.md
# Register File with Mode-Banked Stack Pointer

This block is the architectural register file of a CISC-style CPU core. It stores a bank of general data registers and a bank of address registers, all 32 bits wide. The highest-numbered address register is the stack pointer. It is backed by two physical registers, one used in user mode and one in supervisor mode. The current privilege bit decides which copy is seen. Two combinational read ports serve operand and index fetch, and one write port commits results on the rising clock edge.

Each write carries a register class (data or address), an index and a size code. The write merges the incoming value with the old contents according to that size. For data registers, narrow writes touch only the low lanes. For address registers, word writes are sign-extended, and byte writes are refused with a one-cycle illegal-size flag. The flag is meant for the exception sequencer, which lies outside this block, as do decode and the ALU.

Top module: `bsp_regfile`

## Requirements
- R1: While reset is low, every data register, every address register and both stack pointer copies read as zero, and all of them still read zero once reset is released.
- R2: Each read port returns, combinationally, the selected register. Class bit 0 selects the data registers and class bit 1 selects the address registers. The index picks the register within its class, and either port may read any register.
- R3: A write takes effect at the rising clock edge. A read of the written register in the same cycle returns the value it held before the write.
- R4: Size codes are 00 byte, 01 word, 10 long and 11 reserved. A long write to a data register replaces all 32 bits.
- R5: A byte write to a data register replaces bits 7:0 only, and a word write replaces bits 15:0 only. All other bits keep their old value.
- R6: A word write to an address register stores bits 15:0 of the write data, with bit 15 copied into bits 31:16.
- R7: A long write to an address register stores all 32 bits of the write data.
- R8: A byte write aimed at an address register changes no register, and illegal_size_o is high in that same cycle.
- R9: A write with the reserved size code 11 changes no register in either class, and illegal_size_o is high in that same cycle.
- R10: Address index 7 is the stack pointer. When sup_i is 1, reads and writes of it use the supervisor copy; when sup_i is 0, they use the user copy.
- R11: A write to one stack pointer copy leaves the other copy unchanged.
- R12: With wr_en_i low, no register changes and illegal_size_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_i | input | 1 | Current mode: 1 supervisor, 0 user |
| rd0_cls_i | input | 1 | Read port 0 class (0 data, 1 address) |
| rd0_idx_i | input | 3 | Read port 0 register index |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_cls_i | input | 1 | Read port 1 class |
| rd1_idx_i | input | 3 | Read port 1 register index |
| rd1_data_o | output | 32 | Read port 1 data |
| wr_en_i | input | 1 | Write request |
| wr_cls_i | input | 1 | Write class (0 data, 1 address) |
| wr_idx_i | input | 3 | Write register index |
| wr_size_i | input | 2 | Write size code |
| wr_data_i | input | 32 | Write data |
| illegal_size_o | output | 1 | Pulses when a write request is refused for its size |

## Verification
A read and a write of the same register can fall in the same cycle. The bench provokes this on every write by steering read port 1 onto the write target while the request is held. Before the edge, the port must show the pre-write value from the bench model; after the edge, the merged value. Stack pointer accesses are mixed across both settings of sup_i, so a write to one copy can be judged against a later read of the other copy.

// File: rtl/bsp_regfile_pkg.sv
package bsp_regfile_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSVD = 2'b11
   } size_e;

   typedef enum logic {
      CLS_DATA = 1'b0,
      CLS_ADDR = 1'b1
   } cls_e;

endpackage

// File: rtl/bsp_wr_shaper.sv
module bsp_wr_shaper
   import bsp_regfile_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          wr_en_i,
   input  logic          cls_i,
   input  logic [1:0]    size_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] old_i,
   output logic          commit_o,
   output logic          illegal_o,
   output logic [DW-1:0] merged_o
);

   localparam int HI_W = DW - 16;

   always_comb begin
      commit_o  = 1'b0;
      illegal_o = 1'b0;
      merged_o  = old_i;
      if (wr_en_i) begin
         unique case (size_e'(size_i))
            SZ_BYTE: begin
               if (cls_e'(cls_i) == CLS_ADDR) begin
                  illegal_o = 1'b1;
               end else begin
                  commit_o = 1'b1;
                  merged_o = {old_i[DW-1:8], wdata_i[7:0]};
               end
            end
            SZ_WORD: begin
               commit_o = 1'b1;
               if (cls_e'(cls_i) == CLS_ADDR)
                  merged_o = {{HI_W{wdata_i[15]}}, wdata_i[15:0]};
               else
                  merged_o = {old_i[DW-1:16], wdata_i[15:0]};
            end
            SZ_LONG: begin
               commit_o = 1'b1;
               merged_o = wdata_i;
            end
            default: begin
               illegal_o = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/bsp_data_bank.sv
module bsp_data_bank #(
   parameter int DW    = 32,
   parameter int NDATA = 8,
   parameter int IW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [IW-1:0]       idx_i,
   input  logic [DW-1:0]       din_i,
   output logic [NDATA*DW-1:0] flat_o
);

   for (genvar i = 0; i < NDATA; i++) begin : g_dreg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we_i && (idx_i == IW'(i)))
            q <= din_i;
      end
      assign flat_o[i*DW +: DW] = q;
   end

endmodule

// File: rtl/bsp_addr_bank.sv
module bsp_addr_bank #(
   parameter int DW    = 32,
   parameter int NADDR = 8,
   parameter int IW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sup_i,
   input  logic                we_i,
   input  logic [IW-1:0]       idx_i,
   input  logic [DW-1:0]       din_i,
   output logic [NADDR*DW-1:0] flat_o,
   output logic [DW-1:0]       usp_o,
   output logic [DW-1:0]       ssp_o
);

   localparam int SP_IDX = NADDR - 1;

   for (genvar i = 0; i < SP_IDX; i++) begin : g_areg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we_i && (idx_i == IW'(i)))
            q <= din_i;
      end
      assign flat_o[i*DW +: DW] = q;
   end

   logic          sp_hit;
   logic [DW-1:0] usp_q;
   logic [DW-1:0] ssp_q;

   assign sp_hit = we_i && (idx_i == IW'(SP_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usp_q <= '0;
         ssp_q <= '0;
      end else if (sp_hit) begin
         if (sup_i)
            ssp_q <= din_i;
         else
            usp_q <= din_i;
      end
   end

   assign flat_o[SP_IDX*DW +: DW] = sup_i ? ssp_q : usp_q;
   assign usp_o = usp_q;
   assign ssp_o = ssp_q;

endmodule

// File: rtl/bsp_rd_mux.sv
module bsp_rd_mux #(
   parameter int DW    = 32,
   parameter int NDATA = 8,
   parameter int NADDR = 8,
   parameter int IW    = 3
) (
   input  logic                cls_i,
   input  logic [IW-1:0]       idx_i,
   input  logic [NDATA*DW-1:0] dflat_i,
   input  logic [NADDR*DW-1:0] aflat_i,
   output logic [DW-1:0]       dout_o
);

   always_comb begin
      dout_o = '0;
      if (cls_i) begin
         if (int'(idx_i) < NADDR)
            dout_o = aflat_i[int'(idx_i)*DW +: DW];
      end else begin
         if (int'(idx_i) < NDATA)
            dout_o = dflat_i[int'(idx_i)*DW +: DW];
      end
   end

endmodule

// File: rtl/bsp_regfile.sv
module bsp_regfile
   import bsp_regfile_pkg::*;
#(
   parameter int DW    = 32,
   parameter int NDATA = 8,
   parameter int NADDR = 8,
   parameter int IW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sup_i,
   input  logic          rd0_cls_i,
   input  logic [IW-1:0] rd0_idx_i,
   output logic [DW-1:0] rd0_data_o,
   input  logic          rd1_cls_i,
   input  logic [IW-1:0] rd1_idx_i,
   output logic [DW-1:0] rd1_data_o,
   input  logic          wr_en_i,
   input  logic          wr_cls_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [1:0]    wr_size_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          illegal_size_o
);

   localparam int NRD   = 2;
   localparam int NMAX  = (NDATA > NADDR) ? NDATA : NADDR;
   localparam int IW_LO = $clog2(NMAX);

   if (DW < 32 || (DW % 8) != 0) begin : g_bad_dw
      $error("bsp_regfile: DW must be a multiple of 8 and at least 32");
   end
   if (NDATA < 1) begin : g_bad_ndata
      $error("bsp_regfile: NDATA must be at least 1");
   end
   if (NADDR < 2) begin : g_bad_naddr
      $error("bsp_regfile: NADDR must be at least 2");
   end
   if (IW < IW_LO) begin : g_bad_iw
      $error("bsp_regfile: IW too narrow for the register count");
   end

   logic [NDATA*DW-1:0] data_flat;
   logic [NADDR*DW-1:0] addr_flat;
   logic [DW-1:0]       usp_q;
   logic [DW-1:0]       ssp_q;
   logic [DW-1:0]       wr_old;
   logic [DW-1:0]       wr_merged;
   logic                wr_commit;

   // read port fan-out
   logic          rd_cls [NRD];
   logic [IW-1:0] rd_idx [NRD];
   logic [DW-1:0] rd_dat [NRD];

   assign rd_cls[0]  = rd0_cls_i;
   assign rd_idx[0]  = rd0_idx_i;
   assign rd_cls[1]  = rd1_cls_i;
   assign rd_idx[1]  = rd1_idx_i;
   assign rd0_data_o = rd_dat[0];
   assign rd1_data_o = rd_dat[1];

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      bsp_rd_mux #(
         .DW(DW), .NDATA(NDATA), .NADDR(NADDR), .IW(IW)
      ) u_mux (
         .cls_i  (rd_cls[p]),
         .idx_i  (rd_idx[p]),
         .dflat_i(data_flat),
         .aflat_i(addr_flat),
         .dout_o (rd_dat[p])
      );
   end

   // old contents of the write target, for lane merging
   bsp_rd_mux #(
      .DW(DW), .NDATA(NDATA), .NADDR(NADDR), .IW(IW)
   ) u_old_mux (
      .cls_i  (wr_cls_i),
      .idx_i  (wr_idx_i),
      .dflat_i(data_flat),
      .aflat_i(addr_flat),
      .dout_o (wr_old)
   );

   bsp_wr_shaper #(
      .DW(DW)
   ) u_shaper (
      .wr_en_i  (wr_en_i),
      .cls_i    (wr_cls_i),
      .size_i   (wr_size_i),
      .wdata_i  (wr_data_i),
      .old_i    (wr_old),
      .commit_o (wr_commit),
      .illegal_o(illegal_size_o),
      .merged_o (wr_merged)
   );

   bsp_data_bank #(
      .DW(DW), .NDATA(NDATA), .IW(IW)
   ) u_dbank (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_commit && (cls_e'(wr_cls_i) == CLS_DATA)),
      .idx_i (wr_idx_i),
      .din_i (wr_merged),
      .flat_o(data_flat)
   );

   bsp_addr_bank #(
      .DW(DW), .NADDR(NADDR), .IW(IW)
   ) u_abank (
      .clk   (clk),
      .rst_n (rst_n),
      .sup_i (sup_i),
      .we_i  (wr_commit && (cls_e'(wr_cls_i) == CLS_ADDR)),
      .idx_i (wr_idx_i),
      .din_i (wr_merged),
      .flat_o(addr_flat),
      .usp_o (usp_q),
      .ssp_o (ssp_q)
   );

endmodule

// File: rtl/bsp_regfile_chk.sv
module bsp_regfile_chk #(
   parameter int DW    = 32,
   parameter int NDATA = 8,
   parameter int NADDR = 8,
   parameter int IW    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sup_i,
   input logic                wr_en_i,
   input logic                wr_cls_i,
   input logic [IW-1:0]       wr_idx_i,
   input logic [1:0]          wr_size_i,
   input logic [DW-1:0]       wr_data_i,
   input logic                illegal_size_o,
   input logic [NDATA*DW-1:0] data_flat,
   input logic [NADDR*DW-1:0] addr_flat,
   input logic [DW-1:0]       usp_q,
   input logic [DW-1:0]       ssp_q
);

   localparam int SP_IDX = NADDR - 1;

   logic [IW-1:0] idx_q;
   logic [DW-1:0] d_now;
   logic [DW-1:0] d_prev_tgt;
   logic [DW-1:0] a_prev_tgt;
   logic          sp_wr;
   logic          dbyte_wr;
   logic          dword_wr;
   logic          aword_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= wr_idx_i;
   end

   assign d_now      = (int'(wr_idx_i) < NDATA) ? data_flat[int'(wr_idx_i)*DW +: DW] : '0;
   assign d_prev_tgt = (int'(idx_q) < NDATA) ? data_flat[int'(idx_q)*DW +: DW] : '0;
   assign a_prev_tgt = (int'(idx_q) < NADDR) ? addr_flat[int'(idx_q)*DW +: DW] : '0;

   assign sp_wr    = wr_en_i && wr_cls_i && (wr_idx_i == IW'(SP_IDX));
   assign dbyte_wr = wr_en_i && !wr_cls_i && (wr_size_i == 2'b00) && (int'(wr_idx_i) < NDATA);
   assign dword_wr = wr_en_i && !wr_cls_i && (wr_size_i == 2'b01) && (int'(wr_idx_i) < NDATA);
   assign aword_wr = wr_en_i && wr_cls_i && (wr_size_i == 2'b01) && (int'(wr_idx_i) < SP_IDX);

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (data_flat == '0 && addr_flat == '0 && usp_q == '0 && ssp_q == '0)); // R1

   AST_DATA_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      dbyte_wr |=> (d_prev_tgt[DW-1:8] == $past(d_now[DW-1:8]))); // R5

   AST_DATA_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      dword_wr |=> (d_prev_tgt[DW-1:16] == $past(d_now[DW-1:16]))); // R5

   AST_ADDR_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      aword_wr |=> (a_prev_tgt[DW-1:16] == {(DW-16){$past(wr_data_i[15])}})); // R6

   AST_REFUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_size_o |=> ($stable(data_flat) && $stable(usp_q) && $stable(ssp_q))); // R8

   AST_FLAG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_size_o |-> wr_en_i); // R12

   AST_SSP_HOLD_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr && !sup_i) |=> $stable(ssp_q)); // R11

   AST_USP_HOLD_IN_SUP: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr && sup_i) |=> $stable(usp_q)); // R11

endmodule

bind bsp_regfile bsp_regfile_chk #(
   .DW(DW), .NDATA(NDATA), .NADDR(NADDR), .IW(IW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sup_i         (sup_i),
   .wr_en_i       (wr_en_i),
   .wr_cls_i      (wr_cls_i),
   .wr_idx_i      (wr_idx_i),
   .wr_size_i     (wr_size_i),
   .wr_data_i     (wr_data_i),
   .illegal_size_o(illegal_size_o),
   .data_flat     (data_flat),
   .addr_flat     (addr_flat),
   .usp_q         (usp_q),
   .ssp_q         (ssp_q)
);

// File: tb/sim_bsp_regfile.sv
module sim_bsp_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sup_i = 1'b0;
   logic        rd0_cls_i = 1'b0;
   logic [2:0]  rd0_idx_i = '0;
   logic [31:0] rd0_data_o;
   logic        rd1_cls_i = 1'b0;
   logic [2:0]  rd1_idx_i = '0;
   logic [31:0] rd1_data_o;
   logic        wr_en_i = 1'b0;
   logic        wr_cls_i = 1'b0;
   logic [2:0]  wr_idx_i = '0;
   logic [1:0]  wr_size_i = '0;
   logic [31:0] wr_data_i = '0;
   logic        illegal_size_o;

   always #5 clk = ~clk;

   bsp_regfile u0 (
      .clk(clk), .rst_n(rst_n), .sup_i(sup_i),
      .rd0_cls_i(rd0_cls_i), .rd0_idx_i(rd0_idx_i), .rd0_data_o(rd0_data_o),
      .rd1_cls_i(rd1_cls_i), .rd1_idx_i(rd1_idx_i), .rd1_data_o(rd1_data_o),
      .wr_en_i(wr_en_i), .wr_cls_i(wr_cls_i), .wr_idx_i(wr_idx_i),
      .wr_size_i(wr_size_i), .wr_data_i(wr_data_i),
      .illegal_size_o(illegal_size_o)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] m_d [8];
   logic [31:0] m_a [7];
   logic [31:0] m_usp;
   logic [31:0] m_ssp;

   function automatic logic [31:0] f_get(logic cls, logic [2:0] idx, logic sup);
      if (!cls)          return m_d[idx];
      else if (idx == 7) return sup ? m_ssp : m_usp;
      else               return m_a[idx];
   endfunction

   function automatic logic f_refused(logic cls, logic [1:0] size);
      return (size == 2'b11) || (cls && size == 2'b00);
   endfunction

   function automatic logic [31:0] f_next(logic [31:0] old, logic cls, logic [1:0] size,
                                          logic [31:0] d);
      case (size)
         2'b00:   return {old[31:8], d[7:0]};
         2'b01:   return cls ? {{16{d[15]}}, d[15:0]} : {old[31:16], d[15:0]};
         default: return d;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_wr(logic en, logic cls, logic [2:0] idx, logic [1:0] size,
                        logic [31:0] d, logic sup);
      logic       bad;
      logic [31:0] old;
      @(negedge clk);
      sup_i = sup; wr_en_i = en; wr_cls_i = cls; wr_idx_i = idx;
      wr_size_i = size; wr_data_i = d;
      rd1_cls_i = cls; rd1_idx_i = idx;
      #1;
      bad = en && f_refused(cls, size);
      old = f_get(cls, idx, sup);
      if (!en)
         chk("R12 flag idle", {31'd0, illegal_size_o}, 32'd0);
      else if (size == 2'b11)
         chk("R9 flag", {31'd0, illegal_size_o}, {31'd0, bad});
      else
         chk("R8 flag", {31'd0, illegal_size_o}, {31'd0, bad});
      chk("R3 old value before edge", rd1_data_o, old);
      @(posedge clk);
      if (en && !bad) begin
         if (!cls)          m_d[idx] = f_next(old, cls, size, d);
         else if (idx == 7) begin
            if (sup) m_ssp = f_next(old, cls, size, d);
            else     m_usp = f_next(old, cls, size, d);
         end
         else m_a[idx] = f_next(old, cls, size, d);
      end
      #1 wr_en_i = 1'b0;
   endtask

   task automatic rd_chk(string req, logic cls, logic [2:0] idx, logic sup);
      @(negedge clk);
      sup_i = sup; rd0_cls_i = cls; rd0_idx_i = idx;
      #1;
      chk(req, rd0_data_o, f_get(cls, idx, sup));
   endtask

   task automatic sweep(string req);
      for (int i = 0; i < 8; i++) begin
         rd_chk(req, 1'b0, 3'(i), 1'b0);
         rd_chk(req, 1'b1, 3'(i), 1'b0);
      end
      rd_chk(req, 1'b1, 3'd7, 1'b1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] seed;
      for (int i = 0; i < 8; i++) m_d[i] = '0;
      for (int i = 0; i < 7; i++) m_a[i] = '0;
      m_usp = '0;
      m_ssp = '0;
      seed = $urandom(32'd1234);

      // reset state, observed during and after reset
      repeat (3) @(negedge clk);
      #1 chk("R1 during reset", rd0_data_o, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      sweep("R1 after reset");

      // data registers: long, byte, word merges
      do_wr(1'b1, 1'b0, 3'd3, 2'b10, 32'h1234_5678, 1'b0);
      rd_chk("R4 data long", 1'b0, 3'd3, 1'b0);
      chk("R4 data long value", rd0_data_o, 32'h1234_5678);
      do_wr(1'b1, 1'b0, 3'd3, 2'b00, 32'hAABB_CCDD, 1'b0);
      rd_chk("R5 data byte", 1'b0, 3'd3, 1'b0);
      chk("R5 data byte value", rd0_data_o, 32'h1234_56DD);
      do_wr(1'b1, 1'b0, 3'd3, 2'b01, 32'hAABB_CCDD, 1'b0);
      chk("R5 data word value", rd0_data_o, 32'h1234_CCDD);

      // address registers: sign extension and long
      do_wr(1'b1, 1'b1, 3'd2, 2'b01, 32'h0000_8001, 1'b0);
      rd_chk("R6 addr word neg", 1'b1, 3'd2, 1'b0);
      chk("R6 addr word neg value", rd0_data_o, 32'hFFFF_8001);
      do_wr(1'b1, 1'b1, 3'd2, 2'b01, 32'hFFFF_7FFF, 1'b0);
      chk("R6 addr word pos value", rd0_data_o, 32'h0000_7FFF);
      do_wr(1'b1, 1'b1, 3'd5, 2'b10, 32'hDEAD_BEEF, 1'b0);
      rd_chk("R7 addr long", 1'b1, 3'd5, 1'b0);
      chk("R7 addr long value", rd0_data_o, 32'hDEAD_BEEF);

      // refused writes
      do_wr(1'b1, 1'b1, 3'd2, 2'b00, 32'h0000_0055, 1'b0);
      rd_chk("R8 addr byte refused", 1'b1, 3'd2, 1'b0);
      chk("R8 addr byte value", rd0_data_o, 32'h0000_7FFF);
      do_wr(1'b1, 1'b0, 3'd3, 2'b11, 32'h0F0F_0F0F, 1'b0);
      rd_chk("R9 reserved size data", 1'b0, 3'd3, 1'b0);
      chk("R9 reserved value", rd0_data_o, 32'h1234_CCDD);
      do_wr(1'b1, 1'b1, 3'd7, 2'b11, 32'h0F0F_0F0F, 1'b1);
      rd_chk("R9 reserved size sp", 1'b1, 3'd7, 1'b1);

      // banked stack pointer
      do_wr(1'b1, 1'b1, 3'd7, 2'b10, 32'h0000_1000, 1'b1);
      do_wr(1'b1, 1'b1, 3'd7, 2'b10, 32'h0000_2000, 1'b0);
      rd_chk("R10 supervisor copy", 1'b1, 3'd7, 1'b1);
      chk("R10 supervisor value", rd0_data_o, 32'h0000_1000);
      rd_chk("R11 user copy", 1'b1, 3'd7, 1'b0);
      chk("R11 user value", rd0_data_o, 32'h0000_2000);
      do_wr(1'b1, 1'b1, 3'd7, 2'b01, 32'h0000_9000, 1'b0);
      rd_chk("R11 supervisor untouched", 1'b1, 3'd7, 1'b1);
      chk("R11 supervisor value kept", rd0_data_o, 32'h0000_1000);
      rd_chk("R10 user word sext", 1'b1, 3'd7, 1'b0);
      chk("R10 user word value", rd0_data_o, 32'hFFFF_9000);

      // disabled write
      do_wr(1'b0, 1'b0, 3'd3, 2'b10, 32'h7777_7777, 1'b0);
      rd_chk("R12 disabled write", 1'b0, 3'd3, 1'b0);

      // constrained random traffic
      for (int n = 0; n < 400; n++) begin
         logic        en;
         logic        cls;
         logic [2:0]  idx;
         logic [1:0]  size;
         logic [31:0] d;
         logic        sup;
         en   = ($urandom % 8) != 0;
         cls  = 1'($urandom);
         idx  = (($urandom % 4) == 0) ? 3'd7 : 3'($urandom);
         size = 2'($urandom);
         d    = $urandom;
         sup  = 1'($urandom);
         do_wr(en, cls, idx, size, d, sup);
         rd_chk("R2 random read", 1'($urandom), 3'($urandom), 1'($urandom));
      end
      sweep("R2 final sweep");
      finish_run();
   end

endmodule